// File: doc/BRIEF.md
# Power-Good and Power-Down Mode Controller

This block sets the operating mode of a clock device from a single active-low control pin that changes meaning once. From power-on reset until the pin is first seen high, the pin qualifies power as good. While it stays low in that phase, the clock outputs stay off, but the oscillator domain and the configuration-bus logic keep running. The first high sample sets a sticky role flag. From then until the next power-on reset, the same pin is an asynchronous power-down request.

Three enables come out of the block: one for the oscillator domain, one for the configuration-bus logic, and one global enable that the output gating logic uses to start and stop all clocks at clean boundaries. A pin falling edge in the power-down role takes all three enables low at once, without waiting for a clock edge. A release passes through a synchronizer clocked by the output clock, so the output enable returns after a fixed number of cycles. The oscillator and configuration enables follow the pin level directly in that role, so the oscillator can restart before the synchronizer needs its clock. A two-bit mode output reports the state machine.

Top module: `pwrmode_ctrl`

## Requirements
- R1: After reset, with the pin low, `mode` is 0 (waiting for power good), `out_en` is 0, and `osc_en` and `cfg_en` are 1.
- R2: While the pin stays low in the power-good role, `mode` stays 0, `out_en` stays 0, and `osc_en` and `cfg_en` stay 1 for any duration.
- R3: When the pin goes high in the power-good role and stays high, `mode` becomes 1 (running) and `out_en` rises after the SYNC_STAGES+1-th rising clock edge that follows the pin edge.
- R4: Once `mode` has left 0, it never returns to 0 until `rst_n` is asserted.
- R5: In the power-down role, taking the pin low drives `out_en`, `osc_en` and `cfg_en` to 0 before the next clock edge. `mode` is 2 (powered down) after that edge.
- R6: In the power-down role, `osc_en` and `cfg_en` equal the pin level with no clock delay.
- R7: After a pin rising edge in mode 2, `out_en` rises after the SYNC_STAGES+1-th clock edge. This latency lies within 2 to 6 cycles.
- R8: A high pin pulse that spans fewer than SYNC_STAGES rising clock edges is ignored: `mode` and `out_en` do not change.
- R9: `out_en` is 1 only while `mode` is 1.
- R10: `mode` never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output-domain clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pwr_ctl_n | input | 1 | Dual-role pin: power good before the first high sample, active-low power-down request after it |
| osc_en | output | 1 | Oscillator domain enable |
| cfg_en | output | 1 | Configuration-bus logic enable |
| out_en | output | 1 | Global clock output enable for the gating logic |
| mode | output | 2 | Mode state: 0 waiting for power good, 1 running, 2 powered down |

## Verification
The bench builds the block with SYNC_STAGES set to 3. This gives a resume latency of four cycles, which sits inside the permitted window rather than at its lower edge. With three stages, a glitch that spans two edges can be shown to be ignored, which the default depth could not show. A random phase toggles the pin against a cycle model of the role flag and the synchronizer. That phase reaches repeated power-down and resume cycles, releases cut short mid-synchronization, and the immediate drop of the enables between clock edges.

// File: rtl/pwrmode_pkg.sv
`timescale 1ns/1ps
package pwrmode_pkg;
   localparam int MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      MODE_WAIT_PG = 2'd0,
      MODE_RUN     = 2'd1,
      MODE_PWRDN   = 2'd2
   } mode_e;
endpackage

// File: rtl/pwrmode_sync.sv
`timescale 1ns/1ps
// Release synchronizer. A low pin clears every stage at once; a high level
// reaches level_q only after STAGES rising clock edges.
module pwrmode_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic level_q
);
   logic             clr_n;
   logic [STAGES-1:0] chain;

   assign clr_n = rst_n & pin_n;

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign level_q = chain[STAGES-1];
endmodule

// File: rtl/pwrmode_role.sv
`timescale 1ns/1ps
// Sticky role flag: 0 = power-good qualifier, 1 = power-down request.
module pwrmode_role (
   input  logic clk,
   input  logic rst_n,
   input  logic level_q,
   output logic role_pd
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       role_pd <= 1'b0;
      else if (level_q) role_pd <= 1'b1;
   end

   AST_ROLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      role_pd |=> role_pd); // R4
endmodule

// File: rtl/pwrmode_fsm.sv
`timescale 1ns/1ps
module pwrmode_fsm
   import pwrmode_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  level_q,
   output mode_e state
);
   mode_e state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         MODE_WAIT_PG: state_nx = level_q ? MODE_RUN : MODE_WAIT_PG;
         MODE_RUN:     state_nx = level_q ? MODE_RUN : MODE_PWRDN;
         MODE_PWRDN:   state_nx = level_q ? MODE_RUN : MODE_PWRDN;
         default:      state_nx = MODE_WAIT_PG;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= MODE_WAIT_PG;
      else        state <= state_nx;
   end

   AST_NO_ILLEGAL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      state != mode_e'(2'd3)); // R10
   AST_NEVER_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      (state != MODE_WAIT_PG) |=> (state != MODE_WAIT_PG)); // R4
endmodule

// File: rtl/pwrmode_ctrl.sv
`timescale 1ns/1ps
module pwrmode_ctrl
   import pwrmode_pkg::*;
#(
   parameter int SYNC_STAGES       = 2,
   parameter int MIN_RESUME_CYCLES = 2,
   parameter int MAX_RESUME_CYCLES = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_ctl_n,
   output logic              osc_en,
   output logic              cfg_en,
   output logic              out_en,
   output logic [MODE_W-1:0] mode
);
   localparam int RESUME_CYCLES = SYNC_STAGES + 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_depth
         $error("pwrmode_ctrl: SYNC_STAGES must be at least 2");
      end
      if (RESUME_CYCLES < MIN_RESUME_CYCLES || RESUME_CYCLES > MAX_RESUME_CYCLES) begin : g_bad_latency
         $error("pwrmode_ctrl: resume latency outside the allowed window");
      end
   endgenerate

   logic  level_q;
   logic  role_pd;
   mode_e state;

   pwrmode_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_n   (pwr_ctl_n),
      .level_q (level_q)
   );

   pwrmode_role u_role (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_q (level_q),
      .role_pd (role_pd)
   );

   pwrmode_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_q (level_q),
      .state   (state)
   );

   // Domain enables track the raw pin in the power-down role so the
   // oscillator can restart before the synchronizer needs its clock.
   assign osc_en = ~role_pd | pwr_ctl_n;
   assign cfg_en = ~role_pd | pwr_ctl_n;
   // The synchronizer clears asynchronously, so out_en drops at once.
   assign out_en = (state == MODE_RUN) & level_q;
   assign mode   = state;

   AST_ROLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      role_pd == (state != MODE_WAIT_PG)); // R4
   AST_PG_DOMAINS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (state == MODE_WAIT_PG) |-> (osc_en && cfg_en)); // R2
   AST_PD_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (role_pd && !pwr_ctl_n) |-> (!out_en && !osc_en && !cfg_en)); // R5
   AST_OUT_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_en) |-> $past(level_q)); // R7
endmodule

// File: tb/pwrmode_ctrl_tb.sv
`timescale 1ns/1ps
module pwrmode_ctrl_tb_top;
   localparam int S = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin = 1'b0;
   logic       osc_en, cfg_en, out_en;
   logic [1:0] mode;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   pwrmode_ctrl #(.SYNC_STAGES(S)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_ctl_n (pin),
      .osc_en    (osc_en),
      .cfg_en    (cfg_en),
      .out_en    (out_en),
      .mode      (mode)
   );

   function automatic int exp_latency();
      return S + 1;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   // Pin rises just after a falling edge; count rising edges until out_en.
   task automatic measure(output int n);
      n = 0;
      @(negedge clk); #0.5 pin = 1'b1;
      for (int k = 0; k < 20; k++) begin
         @(posedge clk); n++;
         @(negedge clk);
         if (out_en) break;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; pin = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(5.0 * 100000);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      int lat;
      int cnt;
      int st;
      bit role;
      bit sync_now;
      void'($urandom(32'd4242));

      do_reset();
      @(negedge clk);
      check("R1 mode", mode, 0);
      check("R1 out_en", out_en, 0);
      check("R1 osc_en", osc_en, 1);
      check("R1 cfg_en", cfg_en, 1);

      repeat (20) @(negedge clk);
      check("R2 mode", mode, 0);
      check("R2 out_en", out_en, 0);
      check("R2 osc_en", osc_en, 1);
      check("R2 cfg_en", cfg_en, 1);

      // R8: high across S-1 edges only
      #0.5 pin = 1'b1;
      repeat (S - 1) @(negedge clk);
      pin = 1'b0;
      repeat (6) @(negedge clk);
      check("R8 mode", mode, 0);
      check("R8 out_en", out_en, 0);

      measure(lat);
      check("R3 latency", lat, exp_latency());
      check("R3 mode", mode, 1);
      check("R9 out_en in run", out_en, 1);

      repeat (5) @(negedge clk);
      #0.5 pin = 1'b0;
      #0.5;
      check("R5 out_en at once", out_en, 0);
      check("R5 osc_en at once", osc_en, 0);
      check("R5 cfg_en at once", cfg_en, 0);
      @(negedge clk);
      check("R5 mode", mode, 2);

      // R6: domain enables follow the pin in the power-down role
      #0.5 pin = 1'b1;
      #0.5;
      check("R6 osc_en", osc_en, 1);
      check("R6 cfg_en", cfg_en, 1);
      check("R6 out_en still off", out_en, 0);
      pin = 1'b0;
      #0.5;
      check("R6 osc_en low", osc_en, 0);

      measure(lat);
      check("R7 latency", lat, exp_latency());
      check("R7 window", (lat >= 2 && lat <= 6) ? 1 : 0, 1);

      #0.5 pin = 1'b0;
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         if (mode == 0) check("R4 no return", mode, 2);
      end
      check("R4 mode", mode, 2);

      // R8 in power-down role: short release ignored
      #0.5 pin = 1'b1;
      repeat (S - 1) @(negedge clk);
      pin = 1'b0;
      repeat (4) @(negedge clk);
      check("R8 pd mode", mode, 2);
      check("R8 pd out_en", out_en, 0);

      // Random phase against a cycle model
      do_reset();
      cnt = 0; st = 0; role = 0;
      for (int c = 0; c < 2000; c++) begin
         @(negedge clk);
         #0.5;
         if ($urandom_range(0, 3) == 0) pin = ~pin;
         #0.5;
         sync_now = pin && (cnt >= S);
         check("R10 mode", mode, st);
         check("R9 out_en", out_en, (st == 1 && sync_now) ? 1 : 0);
         check("R6 osc_en", osc_en, (!role || pin) ? 1 : 0);
         check("R6 cfg_en", cfg_en, (!role || pin) ? 1 : 0);
         if (out_en && mode != 1) check("R9 out_en only in run", mode, 1);
         @(posedge clk);
         if (sync_now) begin st = 1; role = 1; end
         else if (st != 0) st = 2;
         cnt = pin ? ((cnt < 15) ? cnt + 1 : cnt) : 0;
      end

      summary();
   end
endmodule